// File: doc/BRIEF.md
# Reference Lock-Acquisition State Controller

This block is the supervisory state machine of a network timing source. It follows whether the phase-locked loop is tracking a chosen reference and walks through five states: Free-run, Pre-Locked, Locked, Holdover and a second pre-lock state (Pre-Locked 2) that is used when leaving Holdover or when a higher-priority reference comes back. The loop itself, the phase detector and the quality checks on each reference are outside the block. Lock-detect and reference-fail come in as ready, qualified flags. A one-second tick drives the timer that bounds each lock attempt.

Each time the controller enters a pre-lock state, a deadline timer starts from zero. If lock is not reported within `TIMEOUT_TICKS` seconds (100 by default), the attempt is abandoned: the controller drops to Holdover and raises a one-cycle request for a different reference. The same request is raised when the reference in use fails. A one-cycle strobe marks every change of state. All outputs are registered.

Top module: `lock_acq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `state_o` reads Free-run (encoding 0), and both `new_ref_req_o` and `state_chg_o` are low. The state encodings are Free-run=0, Pre-Locked=1, Locked=2, Holdover=3 and Pre-Locked 2=4.
- R2: In Free-run, `ref_sel_i` high at a clock edge moves the state to Pre-Locked (1) at that edge.
- R3: In either pre-lock state, `lock_ok_i` high (with `ref_fail_i` low) moves the state to Locked (2). This holds even if the tick that would end the deadline arrives in the same cycle.
- R4: In Locked, `ref_fail_i` high moves the state to Holdover (3) and pulses `new_ref_req_o` for exactly one cycle.
- R5: In Holdover, `ref_sel_i` high moves the state to Pre-Locked 2 (4).
- R6: With `revert_en_i` high, `hp_restored_i` high in Locked or Holdover moves the state to Pre-Locked 2 (4). With `revert_en_i` low, `hp_restored_i` leaves the state unchanged.
- R7: In a pre-lock state, the `TIMEOUT_TICKS`-th `sec_tick_i` pulse counted since entry moves the state to Holdover (3) at that edge, with `new_ref_req_o` high for one cycle. After one tick fewer, the state is unchanged. `new_ref_req_o` is only ever high while the state is Holdover.
- R8: The deadline count begins at zero on every entry to a pre-lock state and stays at zero in all other states. Ticks from an earlier attempt, or ticks received outside pre-lock, do not bring the timeout closer.
- R9: `state_chg_o` is high for exactly the one cycle in which `state_o` first shows a new value, and it is low in every other cycle.
- R10: In either pre-lock state, `ref_fail_i` high moves the state to Holdover (3) with a one-cycle `new_ref_req_o`. This takes priority over `lock_ok_i` in the same cycle.
- R11: In Locked, `ref_fail_i` takes priority over a revertive restoration in the same cycle: the state goes to Holdover (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| ref_sel_i | input | 1 | A reference has been selected and applied to the loop |
| lock_ok_i | input | 1 | Qualified lock indication |
| ref_fail_i | input | 1 | Qualified failure of the reference in use |
| revert_en_i | input | 1 | Revertive operation enabled |
| hp_restored_i | input | 1 | A higher-priority reference has become available again |
| state_o | output | 3 | Current state (0 Free-run, 1 Pre-Locked, 2 Locked, 3 Holdover, 4 Pre-Locked 2) |
| new_ref_req_o | output | 1 | One-cycle request to select another reference |
| state_chg_o | output | 1 | One-cycle strobe on every state change |

## Verification
All three outputs are registered at the same edge that samples the causing inputs. A change driven before edge N is therefore visible from just after edge N, and the request and strobe fall again after edge N+1. The bench drives each stimulus on a falling edge for exactly one cycle and reads the outputs on the next falling edge. It then reads them once more a cycle later to confirm that the pulses have ended. For the deadline, the exit happens at the edge that samples the final tick. The bench therefore sends one tick fewer than the limit, confirms that the state has held, and then sends the last tick and checks at the following falling edge.

// File: rtl/lac_pkg.sv
package lac_pkg;

  typedef enum logic [2:0] {
    ST_FREE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_LOCK  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_PRE2  = 3'd4
  } lac_state_e;

  function automatic logic is_prelock(input lac_state_e s);
    return (s == ST_PRE) || (s == ST_PRE2);
  endfunction

endpackage

// File: rtl/lac_deadline_timer.sv
module lac_deadline_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic armed_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !armed_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = armed_i && tick_i && (cnt_q == LAST);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_i |=> (cnt_q == '0));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);

endmodule

// File: rtl/lac_state_fsm.sv
module lac_state_fsm
  import lac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_sel_i,
  input  logic       lock_ok_i,
  input  logic       ref_fail_i,
  input  logic       revert_en_i,
  input  logic       hp_restored_i,
  input  logic       expire_i,
  output lac_state_e state_o,
  output logic       armed_o,
  output logic       req_o,
  output logic       chg_o
);
  lac_state_e st_q, st_n;
  logic       req_n;
  logic       revert_go;

  assign revert_go = revert_en_i && hp_restored_i;

  always_comb begin
    st_n  = st_q;
    req_n = 1'b0;
    unique case (st_q)
      ST_FREE: begin
        if (ref_sel_i) st_n = ST_PRE;
      end
      ST_PRE, ST_PRE2: begin
        if (ref_fail_i) begin
          st_n  = ST_HOLD;
          req_n = 1'b1;
        end else if (lock_ok_i) begin
          st_n = ST_LOCK;
        end else if (expire_i) begin
          st_n  = ST_HOLD;
          req_n = 1'b1;
        end
      end
      ST_LOCK: begin
        if (ref_fail_i) begin
          st_n  = ST_HOLD;
          req_n = 1'b1;
        end else if (revert_go) begin
          st_n = ST_PRE2;
        end
      end
      ST_HOLD: begin
        if (ref_sel_i || revert_go) st_n = ST_PRE2;
      end
      default: st_n = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_FREE;
      req_o <= 1'b0;
      chg_o <= 1'b0;
    end else begin
      st_q  <= st_n;
      req_o <= req_n;
      chg_o <= (st_n != st_q);
    end
  end

  assign state_o = st_q;
  assign armed_o = is_prelock(st_q);

  // R9
  strobe_match_chk: assert property (@(posedge clk) disable iff (rst)
    chg_o == (st_q != $past(st_q)));

  // R4
  locked_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOCK && ref_fail_i) |=> (st_q == ST_HOLD && req_o));

  // R7
  req_only_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (st_q == ST_HOLD));

  // R3
  prelock_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (is_prelock(st_q) && lock_ok_i && !ref_fail_i) |=> (st_q == ST_LOCK));

  // R6
  revert_off_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && !revert_en_i && !ref_sel_i) |=> (st_q == ST_HOLD));

endmodule

// File: rtl/lock_acq_ctrl.sv
module lock_acq_ctrl
  import lac_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick_i,
  input  logic       ref_sel_i,
  input  logic       lock_ok_i,
  input  logic       ref_fail_i,
  input  logic       revert_en_i,
  input  logic       hp_restored_i,
  output logic [2:0] state_o,
  output logic       new_ref_req_o,
  output logic       state_chg_o
);
  lac_state_e st;
  logic       armed;
  logic       expire;

  lac_deadline_timer #(.LIMIT(TIMEOUT_TICKS)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .armed_i  (armed),
    .tick_i   (sec_tick_i),
    .expire_o (expire)
  );

  lac_state_fsm fsm_i (
    .clk           (clk),
    .rst           (rst),
    .ref_sel_i     (ref_sel_i),
    .lock_ok_i     (lock_ok_i),
    .ref_fail_i    (ref_fail_i),
    .revert_en_i   (revert_en_i),
    .hp_restored_i (hp_restored_i),
    .expire_i      (expire),
    .state_o       (st),
    .armed_o       (armed),
    .req_o         (new_ref_req_o),
    .chg_o         (state_chg_o)
  );

  assign state_o = st;

endmodule

// File: tb/lock_acq_ctrl_tb_top.sv
module lock_acq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 5;

  localparam logic [2:0] S_FREE = 3'd0;
  localparam logic [2:0] S_PRE  = 3'd1;
  localparam logic [2:0] S_LOCK = 3'd2;
  localparam logic [2:0] S_HOLD = 3'd3;
  localparam logic [2:0] S_PRE2 = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, sel = 1'b0, lck = 1'b0, fail = 1'b0, rev = 1'b0, hp = 1'b0;
  logic [2:0] state;
  logic req, chg;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_acq_ctrl #(.TIMEOUT_TICKS(LIM)) dut_i (
    .clk(clk), .rst(rst), .sec_tick_i(tick), .ref_sel_i(sel),
    .lock_ok_i(lck), .ref_fail_i(fail), .revert_en_i(rev),
    .hp_restored_i(hp), .state_o(state), .new_ref_req_o(req),
    .state_chg_o(chg)
  );

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive for one cycle from a falling edge; returns at the next falling edge
  task automatic pulse(input logic s, input logic l, input logic f,
                       input logic h, input logic t);
    sel = s; lck = l; fail = f; hp = h; tick = t;
    @(negedge clk);
    sel = 0; lck = 0; fail = 0; hp = 0; tick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pulse(0, 0, 0, 0, 1);
      idle(1);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; rev = 1'b0;
    idle(2);
    check(state, S_FREE, "R1 state in reset");
    check(req, 0, "R1 req in reset");
    check(chg, 0, "R1 chg in reset");
    rst = 1'b0;
    idle(1);
    check(state, S_FREE, "R1 state after reset");
    check(chg, 0, "R1 chg after reset");
  endtask

  task automatic t_acquire();
    pulse(1, 0, 0, 0, 0);
    check(state, S_PRE, "R2 free to prelock");
    check(chg, 1, "R9 strobe on change");
    idle(1);
    check(chg, 0, "R9 strobe one cycle");
    pulse(0, 1, 0, 0, 0);
    check(state, S_LOCK, "R3 prelock to locked");
    ticks(LIM + 2);
    check(state, S_LOCK, "R8 ticks ignored in locked");
  endtask

  task automatic t_fail_locked();
    pulse(0, 0, 1, 0, 0);
    check(state, S_HOLD, "R4 locked fail to holdover");
    check(req, 1, "R4 request raised");
    idle(1);
    check(req, 0, "R4 request one cycle");
    check(chg, 0, "R9 strobe ends");
  endtask

  task automatic t_revert_off();
    rev = 1'b0;
    pulse(0, 0, 0, 1, 0);
    check(state, S_HOLD, "R6 restore ignored without revertive");
    check(chg, 0, "R9 no strobe without change");
  endtask

  task automatic t_timeout();
    pulse(1, 0, 0, 0, 0);
    check(state, S_PRE2, "R5 holdover to prelock2");
    ticks(LIM - 1);
    check(state, S_PRE2, "R7 one tick short holds");
    check(req, 0, "R7 no request early");
    pulse(0, 0, 0, 0, 1);
    check(state, S_HOLD, "R7 deadline to holdover");
    check(req, 1, "R7 deadline request");
    idle(1);
    check(req, 0, "R7 request one cycle");
  endtask

  task automatic t_restart();
    pulse(1, 0, 0, 0, 0);
    ticks(3);
    pulse(0, 1, 0, 0, 0);
    pulse(0, 0, 1, 0, 0);
    check(state, S_HOLD, "R4 second fail");
    ticks(3);
    pulse(1, 0, 0, 0, 0);
    check(state, S_PRE2, "R5 reenter prelock2");
    ticks(LIM - 1);
    check(state, S_PRE2, "R8 count restarted on entry");
    pulse(0, 1, 0, 0, 0);
    check(state, S_LOCK, "R3 lock from prelock2");
  endtask

  task automatic t_priority();
    rev = 1'b1;
    pulse(0, 0, 0, 1, 0);
    check(state, S_PRE2, "R6 revertive from locked");
    check(chg, 1, "R9 strobe on revert");
    ticks(LIM - 1);
    pulse(0, 1, 0, 0, 1);
    check(state, S_LOCK, "R3 lock beats deadline");
    check(req, 0, "R3 no request on lock");
    pulse(0, 0, 1, 1, 0);
    check(state, S_HOLD, "R11 fail beats restoration");
    pulse(0, 0, 0, 1, 0);
    check(state, S_PRE2, "R6 revertive from holdover");
    pulse(0, 1, 1, 0, 0);
    check(state, S_HOLD, "R10 fail beats lock in prelock");
    check(req, 1, "R10 request on prelock fail");
    rev = 1'b0;
  endtask

  task automatic t_prelock1_timeout();
    do_reset();
    ticks(2);
    pulse(1, 0, 0, 0, 0);
    check(state, S_PRE, "R2 prelock again");
    ticks(LIM - 1);
    check(state, S_PRE, "R8 free-run ticks not counted");
    pulse(0, 0, 0, 0, 1);
    check(state, S_HOLD, "R7 prelock deadline");
    check(req, 1, "R7 prelock deadline request");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_acquire();
    t_fail_locked();
    t_revert_off();
    t_timeout();
    t_restart();
    t_priority();
    t_prelock1_timeout();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule